// File: doc/BRIEF.md
# Four-Buffer Trace Ring Writer

This block receives trace records as a stream of 32-bit words and stores them in memory through a plain write-request port (address plus data). Memory is organised as four buffers of one common size. Each buffer has its own base address register. The buffers are filled in a fixed ring, so software can recycle each one as soon as it is finished. A record is always kept whole inside one buffer.

When a buffer becomes full, or is closed early because the next record cannot fit in it, its done flag is raised. Software takes the data, writes a fresh base address and clears the flag. When the write pointer reaches a buffer whose flag is still set, the ring is blocked and the running bit drops by itself. Software can also start tracing by writing any non-zero value and stop it by writing zero. The buffer size is either a basic unit or twice that unit; the basic unit is the default out of reset.

Top module: `trace_ring_writer`

## Requirements
- R1: Four base address registers, selected by `base_sel` 0..3, are loaded on `base_we`. Each write to a buffer lands at that buffer's register value as it stands at the moment of the write.
- R2: Buffers are filled strictly in the order 0, 1, 2, 3, then 0 again. `cur_idx` only ever steps up by one, modulo 4.
- R3: The buffer size is `UNIT_DW` words after reset. It becomes `2*UNIT_DW` words after `size_we` with `size_big`=1.
- R4: On `ctl_we`, `trace_on` becomes 1 if `ctl_wdata` is non-zero and 0 if it is zero.
- R5: When the current buffer's done flag is set and not being cleared, `trace_on` clears on the next clock edge, unless `ctl_we` is high in that cycle.
- R6: A buffer's done flag (bit i of `done` for buffer i) sets when the buffer is closed and stays set until a `done_clr` pulse on bit i.
- R7: When a word with `rec_first`=1 announces `rec_len` words and the current fill plus `rec_len` exceeds the size, the current buffer is closed and its done flag set. The whole record is then written from offset 0 of the next buffer. No word is written in the closing cycle.
- R8: The n-th word written into a buffer (n from 0) goes to address base + 4*n. A buffer whose fill reaches the size is closed and the pointer moves on with fill 0.
- R9: `rec_ready` is 0 while `trace_on` is 0, while the current buffer's done flag is set, and in a closing cycle.
- R10: Each accepted word appears on `wr_data` with `wr_valid`=1 one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| size_we | input | 1 | Load the size select |
| size_big | input | 1 | 1 selects double-size buffers |
| base_we | input | 1 | Load one base register |
| base_sel | input | 2 | Base register index |
| base_wdata | input | AW | Base address value |
| done_clr | input | 4 | Per-buffer done flag clear pulses |
| ctl_we | input | 1 | Write the trace-on control |
| ctl_wdata | input | 32 | Non-zero starts, zero stops |
| rec_valid | input | 1 | Input word valid |
| rec_ready | output | 1 | Input word accepted when high with valid |
| rec_first | input | 1 | Word is the first of a record |
| rec_len | input | LEN_W | Record length in words, meaningful with rec_first |
| rec_data | input | DW | Input word |
| wr_valid | output | 1 | Write request |
| wr_addr | output | AW | Write byte address |
| wr_data | output | DW | Write data |
| trace_on | output | 1 | Tracing running |
| done | output | 4 | Per-buffer done flags |
| cur_idx | output | 2 | Buffer currently being filled |

## Verification
The assertions assume that base addresses are word aligned, that `rec_len` lies between 1 and the buffer size, and that the size select is not changed while a buffer is partly filled. They also assume the input holds a word steady until it is accepted. The bench programs only aligned bases and sends records of 4 or 8 words against a 16-word unit. It changes the size only while tracing is stopped and the pointer sits at an empty buffer. Its driver keeps each word on the input until `rec_ready` is seen.

// File: rtl/trace_ring_writer.sv
module trace_ring_writer #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LEN_W   = 4,
  parameter int UNIT_DW = 524288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             size_we,
  input  logic             size_big,
  input  logic             base_we,
  input  logic [1:0]       base_sel,
  input  logic [AW-1:0]    base_wdata,
  input  logic [3:0]       done_clr,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             rec_valid,
  output logic             rec_ready,
  input  logic             rec_first,
  input  logic [LEN_W-1:0] rec_len,
  input  logic [DW-1:0]    rec_data,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             trace_on,
  output logic [3:0]       done,
  output logic [1:0]       cur_idx
);
  localparam int FILL_W = $clog2(2*UNIT_DW) + 1;

  logic [AW-1:0]     base [4];
  logic              big;
  logic [FILL_W-1:0] fill;
  logic [FILL_W-1:0] limit;
  logic [FILL_W:0]   need;
  logic [1:0]        nxt;
  logic              live, nofit, take, close, last, adv;

  assign limit     = big ? FILL_W'(2*UNIT_DW) : FILL_W'(UNIT_DW);
  assign need      = {1'b0, fill} + (FILL_W+1)'(rec_len);
  assign live      = trace_on & ~done[cur_idx];
  assign nofit     = rec_valid & rec_first & (need > {1'b0, limit});
  assign rec_ready = live & ~nofit;
  assign take      = rec_valid & rec_ready;
  assign close     = live & nofit;
  assign last      = take & ((fill + 1'b1) >= limit);
  assign adv       = close | last;
  assign nxt       = cur_idx + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) base[i] <= '0;
      big      <= 1'b0;
      fill     <= '0;
      cur_idx  <= 2'd0;
      done     <= 4'd0;
      trace_on <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (base_we) base[base_sel] <= base_wdata;
      if (size_we) big <= size_big;

      wr_valid <= take;
      if (take) begin
        wr_addr <= base[cur_idx] + (AW'(fill) << 2);
        wr_data <= rec_data;
      end

      if (adv)       fill <= '0;
      else if (take) fill <= fill + 1'b1;
      if (adv) cur_idx <= nxt;

      done <= (done & ~done_clr) | (adv ? (4'b0001 << cur_idx) : 4'b0000);

      if (ctl_we)
        trace_on <= |ctl_wdata;
      else if (trace_on && done[cur_idx] && !done_clr[cur_idx])
        trace_on <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_ring_writer_chk.sv
module trace_ring_writer_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    done_clr,
  input logic          ctl_we,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [DW-1:0] rec_data,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          trace_on,
  input logic [3:0]    done,
  input logic [1:0]    cur_idx
);
  a_r2_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> cur_idx == $past(cur_idx) + 2'd1);

  a_r6_done_marks_current: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ~$past(done)) != 4'd0 |-> (done & ~$past(done)) == (4'b0001 << $past(cur_idx)));

  a_r9_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |-> (trace_on && !done[cur_idx]));

  a_r10_write_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready) |=> (wr_valid && wr_data == $past(rec_data)));

  a_r5_blocked_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_on && done[cur_idx] && !done_clr[cur_idx] && !ctl_we) |=> !trace_on);

  a_r8_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00);
endmodule

bind trace_ring_writer trace_ring_writer_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_trace_ring_writer.sv
`timescale 1ns/1ps
module test_trace_ring_writer;
  localparam int AW = 32, DW = 32, LEN_W = 4, UNIT = 16;

  logic clk = 0, rst_n = 0;
  logic size_we = 0, size_big = 0, base_we = 0, ctl_we = 0;
  logic [1:0] base_sel = 0;
  logic [AW-1:0] base_wdata = 0;
  logic [3:0] done_clr = 0;
  logic [31:0] ctl_wdata = 0;
  logic rec_valid = 0, rec_first = 0;
  logic [LEN_W-1:0] rec_len = 0;
  logic [DW-1:0] rec_data = 0;
  logic rec_ready, wr_valid, trace_on;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [3:0] done;
  logic [1:0] cur_idx;

  trace_ring_writer #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .UNIT_DW(UNIT)) i_trace_ring_writer (
    .clk(clk), .rst_n(rst_n), .size_we(size_we), .size_big(size_big),
    .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
    .done_clr(done_clr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_first(rec_first),
    .rec_len(rec_len), .rec_data(rec_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .trace_on(trace_on),
    .done(done), .cur_idx(cur_idx));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  logic [AW-1:0] mb [4];
  int m_cur = 0, m_fill = 0, m_size = UNIT;
  int seq = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0)
        chk(0, "R10 unexpected write", {wr_addr, wr_data}, 64'd0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R8/R10 write addr,data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic m_adv();
    m_cur = (m_cur + 1) % 4;
    m_fill = 0;
  endtask

  task automatic set_base(input int i, input logic [AW-1:0] v);
    base_we = 1; base_sel = 2'(i); base_wdata = v; mb[i] = v;
    @(negedge clk); base_we = 0;
  endtask

  task automatic ctl(input logic [31:0] v);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic clr(input logic [3:0] m);
    done_clr = m;
    @(negedge clk); done_clr = 0;
  endtask

  // R7: the model closes the buffer when the record cannot fit
  task automatic send_rec(input int len);
    if (m_fill + len > m_size) m_adv();
    for (int k = 0; k < len; k++) begin
      int tries = 0;
      rec_valid = 1; rec_first = (k == 0); rec_len = LEN_W'(len);
      seq++; rec_data = 32'hA500_0000 + 32'(seq);
      #1;
      while (!rec_ready && tries < 20) begin
        @(negedge clk); #1; tries++;
      end
      if (rec_ready) begin
        exp_q.push_back({mb[m_cur] + 32'(4 * m_fill), rec_data});
        m_fill++;
        if (m_fill >= m_size) m_adv();
      end else
        chk(0, "R9 ready never came", 0, 1);
      @(negedge clk);
    end
    rec_valid = 0; rec_first = 0;
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(trace_on == 0 && done == 0 && cur_idx == 0 && wr_valid == 0, "R4 reset state",
        {trace_on, done, cur_idx, wr_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    rec_valid = 1; rec_first = 1; rec_len = 4; #1;
    chk(rec_ready == 0, "R9 ready low while stopped", rec_ready, 0);
    @(negedge clk); rec_valid = 0; rec_first = 0;

    set_base(0, 32'h1000_0000);
    set_base(1, 32'h2000_0000);
    set_base(2, 32'h3000_0000);
    set_base(3, 32'h4000_0000);
    ctl(32'h0000_0005);
    chk(trace_on == 1, "R4 non-zero starts", trace_on, 1);

    // R3 default size: 16 words fill buffer 0
    for (int r = 0; r < 4; r++) send_rec(4);
    chk(done == 4'b0001 && cur_idx == 1, "R3/R6 buffer0 full at unit size", {done, cur_idx}, {4'b0001, 2'd1});

    for (int r = 0; r < 2; r++) send_rec(8);
    chk(done == 4'b0011 && cur_idx == 2, "R2 buffer1 then step", {done, cur_idx}, {4'b0011, 2'd2});

    send_rec(4);
    send_rec(8);
    send_rec(8);
    chk(done == 4'b0111 && cur_idx == 3, "R7 early close on no-fit", {done, cur_idx}, {4'b0111, 2'd3});

    clr(4'b0001);
    chk(done == 4'b0110, "R6 clear pulse", done, 4'b0110);
    send_rec(8);
    chk(done == 4'b1110 && cur_idx == 0, "R2 wrap to buffer 0", {done, cur_idx}, {4'b1110, 2'd0});
    chk(trace_on == 1, "R5 free buffer keeps running", trace_on, 1);

    set_base(0, 32'h5000_0100);
    for (int r = 0; r < 4; r++) send_rec(4);
    repeat (2) @(negedge clk);
    chk(trace_on == 0 && cur_idx == 1, "R5 blocked ring stops trace", {trace_on, cur_idx}, {1'b0, 2'd1});
    rec_valid = 1; rec_first = 1; rec_len = 4; #1;
    chk(rec_ready == 0, "R9 ready low when blocked", rec_ready, 0);
    @(negedge clk); rec_valid = 0; rec_first = 0;

    clr(4'b1110);
    chk(done == 4'b0001, "R6 multi clear", done, 4'b0001);
    set_base(1, 32'h6000_0000);
    ctl(32'h0000_0080);
    rec_valid = 1; rec_first = 1; rec_len = 4; #1;
    chk(trace_on == 1 && rec_ready == 1, "R4 restart ready", {trace_on, rec_ready}, 2'b11);
    rec_valid = 0; rec_first = 0;
    @(negedge clk);
    ctl(32'h0);
    rec_valid = 1; rec_first = 1; rec_len = 4; #1;
    chk(trace_on == 0 && rec_ready == 0, "R4 zero stops", {trace_on, rec_ready}, 2'b00);
    rec_valid = 0; rec_first = 0;
    @(negedge clk);

    size_we = 1; size_big = 1; @(negedge clk); size_we = 0;
    m_size = 2 * UNIT;
    ctl(32'h1);
    for (int r = 0; r < 4; r++) send_rec(4);
    chk(done == 4'b0001 && cur_idx == 1, "R3 double size not full at 16", {done, cur_idx}, {4'b0001, 2'd1});
    for (int r = 0; r < 4; r++) send_rec(4);
    chk(done == 4'b0011 && cur_idx == 2, "R3 double size full at 32", {done, cur_idx}, {4'b0011, 2'd2});
    chk(trace_on == 1, "R4 still running", trace_on, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all writes seen", 64'(exp_q.size()), 0);
    chk(m_cur == cur_idx && m_fill == 0, "R1/R8 pointer agrees", {30'd0, cur_idx}, 64'(m_cur));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule